// File: doc/BRIEF.md
# Dual-Personality Floppy Controller Register Front-End

This block is the bus-facing register layer of a floppy disk controller that wakes up in an older soft-switch personality and can be moved into a newer register-file personality. In the soft-switch personality, an access to a register slot does not carry meaning through its data. The slot number alone sets or clears one of eight control latches: four stepper phases, motor, drive select and the two state latches Q6 and Q7. When Q6 and Q7 are both high, a write is steered to the data port (motor on) or to the mode port (motor off). A fixed four-write key sent to the mode port swaps the block into the register-file personality, and only a reset brings it back.

In the register-file personality, the block holds an 8-bit phase register and an 8-bit mode register. The mode register is changed through separate clear-bits and set-bits ports. A handshake status register reports a "sense" flag when the phase register selects the drive-present query, which answers that no drive is attached. The block has no disk data path. Data, mark, CRC, parameter and setup writes are taken and dropped, and the matching reads return zero.

The bus is synchronous, with a slot index in address bits [12:9], a write strobe, a read strobe (one strobe per cycle) and registered 8-bit read data.

Top module: `fdc_regfront`

## Requirements
- R1: A synchronous active-low reset gives reg_mode=0, sw_latch=0x00, mode_bits=0x00 and rdata=0x00, clears the phase register and returns the unlock key tracker to its first step.
- R2: In soft-switch mode, any read or write to slot s (s = addr[12:9]; addr[8:0] ignored) sets latch bit s>>1 of sw_latch to s&1. The bit order is 0-3 phases, 4 motor, 5 drive select, 6 Q6, 7 Q7.
- R3: In soft-switch mode every read returns rdata=0x00 one cycle after the read strobe.
- R4: A soft-switch write counts as a mode-port write when, after that access has updated its own latch, Q6=1, Q7=1 and motor=0. Mode-port writes of 0x57, 0x17, 0x57, 0x57 in that order raise reg_mode in the cycle after the fourth write.
- R5: A mode-port write whose data does not match the value expected next leaves the key tracker on its current step, with no advance and no restart.
- R6: A write with Q6=1, Q7=1 and motor=1 goes to the data port and does not advance the key tracker.
- R7: Once reg_mode is 1 it stays 1 until reset, and in that mode accesses leave sw_latch unchanged.
- R8: In register mode, a write to slot 4 loads the phase register, and a read of slot 12 returns it on rdata in the cycle after the read strobe.
- R9: In register mode, a write to slot 6 clears the mode_bits bits that are 1 in the data, and a write to slot 7 sets the mode_bits bits that are 1 in the data.
- R10: In register mode, a read of slot 15 returns 0x08 when the phase register holds 0x77, and returns 0x00 otherwise.
- R11: In register mode, writes to slots 0, 1, 2, 3 and 5 change neither the phase register nor mode_bits, and reads of slots 8-11, 13 and 14 return 0x00.
- R12: rdata holds its value through every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 13 | Byte address in the 8 KiB window; bits [12:9] select the slot |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| reg_mode | output | 1 | 1 when the register-file personality is active |
| sw_latch | output | 8 | Soft-switch control latches |
| mode_bits | output | 8 | Register-file mode register |

## Verification
Every result of this block appears one cycle after the strobe that causes it. The latch bank, the reg_mode flag after the fourth key write, mode_bits and the phase register all change on the clock edge that samples the access. rdata is loaded on the edge that samples the read strobe. The bench drives each access on a falling edge and holds it across one rising edge. It samples all outputs on the next falling edge, so each check sees the value due exactly one cycle after its stimulus. Idle cycles are then added to confirm that rdata and reg_mode keep their values.

// File: rtl/fdc_rf_pkg.sv
package fdc_rf_pkg;

    localparam int unsigned DATA_W   = 8;
    localparam int unsigned IDX_W    = 4;
    localparam int unsigned N_LATCH  = 1 << (IDX_W - 1);

    // latch positions within the soft-switch bank
    localparam int unsigned LT_MOTOR = 4;
    localparam int unsigned LT_Q6    = 6;
    localparam int unsigned LT_Q7    = 7;

    // register-file personality slots
    localparam logic [IDX_W-1:0] WS_PHASE     = 4'd4;
    localparam logic [IDX_W-1:0] WS_MODE_CLR  = 4'd6;
    localparam logic [IDX_W-1:0] WS_MODE_SET  = 4'd7;
    localparam logic [IDX_W-1:0] RS_PHASE     = 4'd12;
    localparam logic [IDX_W-1:0] RS_HANDSHAKE = 4'd15;

    localparam logic [DATA_W-1:0] SENSE_FLAG     = 8'h08;
    localparam logic [DATA_W-1:0] NO_DRIVE_QUERY = 8'h77;

    // unlock key, first value in the low byte
    localparam logic [4*DATA_W-1:0] KEY_SEQ = {8'h57, 8'h57, 8'h17, 8'h57};

endpackage

// File: rtl/fdc_latch_bank.sv
module fdc_latch_bank #(
    parameter int unsigned IDX_W   = fdc_rf_pkg::IDX_W,
    localparam int unsigned N_LATCH = 1 << (IDX_W - 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch,
    input  logic [IDX_W-1:0]   idx,
    output logic [N_LATCH-1:0] latch_q,
    output logic [N_LATCH-1:0] latch_nxt
);

    typedef struct packed {
        logic [N_LATCH-1:0] bits;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [N_LATCH-1:0] hit;

    // one select line per latch
    for (genvar i = 0; i < N_LATCH; i++) begin : g_hit
        assign hit[i] = touch && (idx[IDX_W-1:1] == (IDX_W-1)'(i));
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < N_LATCH; i++) begin
            if (hit[i]) begin
                bank_d.bits[i] = idx[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign latch_q   = bank_q.bits;
    assign latch_nxt = bank_d.bits;

endmodule

// File: rtl/fdc_unlock_seq.sv
module fdc_unlock_seq #(
    parameter int unsigned DATA_W = fdc_rf_pkg::DATA_W,
    parameter int unsigned STEPS  = 4,
    parameter logic [STEPS*DATA_W-1:0] SEQ = fdc_rf_pkg::KEY_SEQ,
    localparam int unsigned STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    output logic              unlocked
);

    localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              open;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [DATA_W-1:0] want;

    always_comb begin
        want = SEQ[seq_q.step * DATA_W +: DATA_W];
    end

    always_comb begin
        seq_d = seq_q;
        if (key_wr && !seq_q.open && (key_data == want)) begin
            if (seq_q.step == LAST) begin
                seq_d.open = 1'b1;
                seq_d.step = '0;
            end else begin
                seq_d.step = seq_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign unlocked = seq_q.open;

endmodule

// File: rtl/fdc_regfile.sv
module fdc_regfile
    import fdc_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] phase,
    output logic [DATA_W-1:0] mode_bits,
    output logic [DATA_W-1:0] rd_val
);

    typedef struct packed {
        logic [DATA_W-1:0] phase;
        logic [DATA_W-1:0] mode;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (wr) begin
            unique case (idx)
                WS_PHASE:    rf_d.phase = wdata;
                WS_MODE_CLR: rf_d.mode  = rf_q.mode & ~wdata;
                WS_MODE_SET: rf_d.mode  = rf_q.mode | wdata;
                default:     rf_d       = rf_q;
            endcase
        end
    end

    always_comb begin
        unique case (idx)
            RS_PHASE:     rd_val = rf_q.phase;
            RS_HANDSHAKE: rd_val = (rf_q.phase == NO_DRIVE_QUERY) ? SENSE_FLAG : '0;
            default:      rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign phase     = rf_q.phase;
    assign mode_bits = rf_q.mode;

endmodule

// File: rtl/fdc_regfront.sv
module fdc_regfront
    import fdc_rf_pkg::*;
#(
    parameter int unsigned ADDR_W     = 13,
    parameter int unsigned SLOT_SHIFT = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [7:0]        rdata,
    output logic              reg_mode,
    output logic [7:0]        sw_latch,
    output logic [7:0]        mode_bits
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } out_t;

    out_t out_d, out_q;

    logic [IDX_W-1:0]   idx;
    logic               legacy;
    logic [N_LATCH-1:0] lat_q, lat_nxt;
    logic               key_wr;
    logic               rf_wr;
    logic [DATA_W-1:0]  rf_rd, phase_unused;
    logic               unused_low_addr;

    assign idx             = addr[SLOT_SHIFT +: IDX_W];
    assign unused_low_addr = ^addr[SLOT_SHIFT-1:0];
    assign legacy          = !reg_mode;

    fdc_latch_bank #(.IDX_W(IDX_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (legacy && (wr_en || rd_en)),
        .idx       (idx),
        .latch_q   (lat_q),
        .latch_nxt (lat_nxt)
    );

    // the access itself updates its latch before the steering decision
    assign key_wr = wr_en && legacy && lat_nxt[LT_Q6] && lat_nxt[LT_Q7]
                    && !lat_nxt[LT_MOTOR];

    fdc_unlock_seq #(.DATA_W(DATA_W), .STEPS(4), .SEQ(KEY_SEQ)) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_data (wdata),
        .unlocked (reg_mode)
    );

    assign rf_wr = wr_en && reg_mode;

    fdc_regfile u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (rf_wr),
        .idx       (idx),
        .wdata     (wdata),
        .phase     (phase_unused),
        .mode_bits (mode_bits),
        .rd_val    (rf_rd)
    );

    always_comb begin
        out_d = out_q;
        if (rd_en) begin
            out_d.rdata = legacy ? '0 : rf_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rdata    = out_q.rdata;
    assign sw_latch = lat_q;

endmodule

// File: rtl/fdc_regfront_chk.sv
module fdc_regfront_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [12:0] addr,
    input logic        wr_en,
    input logic        rd_en,
    input logic [7:0]  rdata,
    input logic        reg_mode,
    input logic [7:0]  sw_latch,
    input logic [7:0]  mode_bits
);

    a_r7_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        reg_mode |=> reg_mode);

    a_r7_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        reg_mode |=> $stable(sw_latch));

    a_r3_legacy_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !reg_mode) |=> (rdata == 8'h00));

    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    a_r9_mode_bits_legacy: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_mode |=> $stable(mode_bits));

    a_r10_handshake_values: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_mode && addr[12:9] == 4'd15) |=>
            ((rdata & 8'hF7) == 8'h00));

    a_r4_unlock_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_mode && !wr_en) |=> !reg_mode);

    a_r2_one_latch_per_access: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_mode |=> ($countones(sw_latch ^ $past(sw_latch)) <= 1));

endmodule

bind fdc_regfront fdc_regfront_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rdata     (rdata),
    .reg_mode  (reg_mode),
    .sw_latch  (sw_latch),
    .mode_bits (mode_bits)
);

// File: tb/fdc_regfront_tb.sv
`timescale 1ns/1ps
module fdc_regfront_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic        reg_mode;
    logic [7:0]  sw_latch;
    logic [7:0]  mode_bits;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fdc_regfront u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .reg_mode(reg_mode), .sw_latch(sw_latch), .mode_bits(mode_bits)
    );

    typedef struct packed {
        logic       wr;
        logic [3:0] slot;
        logic [7:0] data;
        logic [7:0] exp_lat;
    } vec_t;

    // soft-switch walk from reset; expected latch image after each access
    localparam vec_t VECS [12] = '{
        '{1'b1, 4'd1,  8'h00, 8'h01},
        '{1'b0, 4'd3,  8'h00, 8'h03},
        '{1'b1, 4'd9,  8'h00, 8'h13},
        '{1'b0, 4'd2,  8'h00, 8'h11},
        '{1'b1, 4'd11, 8'h00, 8'h31},
        '{1'b0, 4'd13, 8'h00, 8'h71},
        '{1'b1, 4'd15, 8'h57, 8'hF1},
        '{1'b0, 4'd8,  8'h00, 8'hE1},
        '{1'b1, 4'd0,  8'h00, 8'hE0},
        '{1'b0, 4'd14, 8'h00, 8'h60},
        '{1'b1, 4'd7,  8'h00, 8'h68},
        '{1'b0, 4'd10, 8'h00, 8'h48}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    // drive on falling edge, hold across one rising edge, release on next fall
    task automatic access(input logic wr, input logic [3:0] slot, input logic [7:0] d);
        @(negedge clk);
        addr  = {slot, 9'h1A5};
        wdata = d;
        wr_en = wr;
        rd_en = !wr;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic key_write(input logic [7:0] d);
        access(1'b1, 4'd15, d);
    endtask

    task automatic unlock();
        access(1'b0, 4'd13, 8'h00);
        access(1'b0, 4'd8, 8'h00);
        key_write(8'h57); key_write(8'h17); key_write(8'h57); key_write(8'h57);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 reg_mode", {7'd0, reg_mode}, 8'h00);
        check("R1 sw_latch", sw_latch, 8'h00);
        check("R1 mode_bits", mode_bits, 8'h00);
        check("R1 rdata", rdata, 8'h00);

        // R2 / R3 table walk
        for (int i = 0; i < 12; i++) begin
            access(VECS[i].wr, VECS[i].slot, VECS[i].data);
            check("R2 latch", sw_latch, VECS[i].exp_lat);
            if (!VECS[i].wr) check("R3 legacy read", rdata, 8'h00);
            check("R6 no unlock", {7'd0, reg_mode}, 8'h00);
        end

        // R6: data-port writes (motor on) never advance the key
        do_reset();
        access(1'b0, 4'd13, 8'h00);
        access(1'b0, 4'd9, 8'h00);
        for (int i = 0; i < 4; i++) key_write(8'h57);
        check("R6 data port", {7'd0, reg_mode}, 8'h00);

        // R5: mismatches hold the step (0x57 at step 1, 0x33 at step 2)
        access(1'b0, 4'd8, 8'h00);
        key_write(8'h57); key_write(8'h57); key_write(8'h17);
        key_write(8'h33); key_write(8'h57);
        check("R5 held step", {7'd0, reg_mode}, 8'h00);
        key_write(8'h57);
        check("R4 unlocked", {7'd0, reg_mode}, 8'h01);
        check("R4 latches", sw_latch, 8'hC0);

        // R7: latches frozen, mode sticky
        access(1'b1, 4'd1, 8'h00);
        access(1'b0, 4'd8, 8'h00);
        check("R7 latch frozen", sw_latch, 8'hC0);
        check("R7 sticky", {7'd0, reg_mode}, 8'h01);

        // R8 phase, R10 handshake, R12 hold
        access(1'b1, 4'd4, 8'h5A);
        access(1'b0, 4'd12, 8'h00);
        check("R8 phase", rdata, 8'h5A);
        access(1'b0, 4'd15, 8'h00);
        check("R10 no sense", rdata, 8'h00);
        access(1'b1, 4'd4, 8'h77);
        access(1'b0, 4'd15, 8'h00);
        check("R10 sense", rdata, 8'h08);
        access(1'b0, 4'd12, 8'h00);
        check("R8 phase 77", rdata, 8'h77);
        repeat (3) @(negedge clk);
        check("R12 hold", rdata, 8'h77);

        // R9 set/clear ports
        access(1'b1, 4'd7, 8'hA5);
        check("R9 set", mode_bits, 8'hA5);
        access(1'b1, 4'd6, 8'h81);
        check("R9 clear", mode_bits, 8'h24);
        access(1'b1, 4'd7, 8'h03);
        check("R9 set2", mode_bits, 8'h27);

        // R11 ignored writes and zero reads
        foreach (VECS[i]) begin end
        for (int s = 0; s < 6; s++) begin
            logic [3:0] ws;
            ws = (s == 4) ? 4'd5 : 4'(s);
            if (s < 5) access(1'b1, ws, 8'hFF);
        end
        check("R11 mode kept", mode_bits, 8'h27);
        access(1'b0, 4'd12, 8'h00);
        check("R11 phase kept", rdata, 8'h77);
        for (int s = 8; s < 15; s++) begin
            if (s != 12) begin
                access(1'b0, 4'd12, 8'h00);
                access(1'b0, 4'(s), 8'h00);
                check("R11 zero read", rdata, 8'h00);
            end
        end

        // R1 reset from register mode, then reopen
        do_reset();
        check("R1 mode cleared", {7'd0, reg_mode}, 8'h00);
        check("R1 mode_bits cleared", mode_bits, 8'h00);
        unlock();
        check("R4 reopen", {7'd0, reg_mode}, 8'h01);
        access(1'b0, 4'd12, 8'h00);
        check("R1 phase cleared", rdata, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule